// File: doc/BRIEF.md
# Perturbation SAR Weight Calibrator

This block is the digital back end of a sub-radix-2 successive-approximation converter that digitizes every analog sample twice. The first conversion is made with a small offset added in the analog domain and the second with the same offset subtracted. Each conversion delivers a 14-bit raw code whose bits carry non-binary weights. The calibrator maps each raw code to a fixed-point value by summing the learned weight of every set bit. From the two values of one sample it forms a mismatch term: their difference less twice the learned digital image of the injected offset. A least-mean-squares loop drives this term toward zero by nudging each bit weight and the offset estimate. The calibrated 12-bit result is the rounded mean of the two values, in which the injected offset cancels.

Once the weights have settled, the `freeze` input stops learning. In that mode every incoming code is a plain, unperturbed conversion and is converted on its own, so the sample rate can double. The adaptation gain is a power of two chosen by the `step_shift` input. Weights and offset carry 8 fractional bits below the output LSB.

Top module: `sar_perturb_cal`

## Requirements
- R1: After reset, weight i (bit 0 = LSB) holds a nominal value in 1/256-LSB units: w0 = 152 and wi = floor(w(i-1)·476/256), a radix near 1.86. The offset estimate holds 6400 (25 LSB).
- R2: A raw code is valued as the sum of the current weights of its set bits, in 1/256-LSB units.
- R3: While `freeze` is low, accepted codes alternate: first the positive-offset code, then the negative-offset code. `out_valid` is high in the cycle after the second code is accepted and low in the cycle after the first.
- R4: When a pair completes, `err_data` is loaded with d+ − d− − 2·Δd. This uses the weights and offset that were in force before the update, and the value is held until the next pair.
- R5: On pair completion, u = err >>> step_shift (arithmetic). Weight i is decreased by u where the positive code has bit i set and the negative code does not, and increased by u in the opposite case. Δd is increased by u. Nothing else changes the weights or Δd.
- R6: The pair result is ((d+ + d−) >>> 1) rounded to nearest as (x + 128) >>> 8, then clamped to 0..4095.
- R7: While `freeze` is high, every accepted code is converted on its own. The rounded and clamped value appears with `out_valid` in the next cycle, and the weights and Δd stay unchanged.
- R8: `freeze` high clears the pairing, so the first code accepted after `freeze` falls is treated as a positive-offset code.
- R9: Values below zero give 0 and values above 4095 give 4095 on `out_data`.
- R10: During and directly after reset, `out_valid`, `out_data` and `err_data` are 0.
- R11: `out_valid` is low in any cycle that follows a cycle with no code accepted; `out_data` then holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| freeze | input | 1 | Hold weights; treat each code as a single conversion |
| step_shift | input | 5 | LMS gain as a right-shift amount |
| code_valid | input | 1 | A raw code is present this cycle |
| code | input | 14 | Raw non-binary conversion code |
| out_valid | output | 1 | Calibrated result valid |
| out_data | output | 12 | Calibrated, rounded, clamped result |
| err_data | output | 30 | Last pair mismatch term, 1/256-LSB units, signed |

## Verification
Every result of this block appears exactly one cycle after the edge that accepts the code completing it. A frozen single is due one cycle after its own code, and a pair result and its mismatch term are due one cycle after the negative-offset code. The weights changed by that update first affect the next code accepted. The bench drives inputs on the falling edge. Its behavioural model then computes the state expected after the following rising edge, and every output is compared against that at the next falling edge, on every cycle, including idle ones where the held values are checked.

// File: rtl/sar_cal_pkg.sv
package sar_cal_pkg;

   typedef enum logic {
      PH_POS = 1'b0,
      PH_NEG = 1'b1
   } cal_phase_e;

   // Nominal weight of bit idx: LSB value scaled up by radix_q/256 per bit.
   function automatic longint nominal_weight(input int idx, input longint lsb_q,
                                             input longint radix_q);
      longint w;
      w = lsb_q;
      for (int k = 0; k < idx; k++) begin
         w = (w * radix_q) >>> 8;
      end
      return w;
   endfunction

endpackage

// File: rtl/sar_code_weigher.sv
module sar_code_weigher #(
   parameter int RAW_W = 14,
   parameter int WGT_W = 24,
   parameter int ACC_W = 30
) (
   input  logic [RAW_W-1:0]        code_i,
   input  logic signed [WGT_W-1:0] wgt_i [RAW_W],
   output logic signed [ACC_W-1:0] sum_o
);

   localparam int EXT_W = ACC_W - WGT_W;

   if (EXT_W < 1) begin : g_bad_width
      $error("sar_code_weigher: ACC_W must exceed WGT_W");
   end

   logic signed [ACC_W-1:0] term [RAW_W];

   for (genvar g = 0; g < RAW_W; g++) begin : g_term
      assign term[g] = code_i[g] ? {{EXT_W{wgt_i[g][WGT_W-1]}}, wgt_i[g]} : '0;
   end

   always_comb begin
      sum_o = '0;
      for (int k = 0; k < RAW_W; k++) begin
         sum_o = sum_o + term[k];
      end
   end

endmodule

// File: rtl/sar_round_sat.sv
module sar_round_sat #(
   parameter int ACC_W         = 30,
   parameter int OUT_W         = 12,
   parameter int FRAC_W        = 8,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic signed [ACC_W-1:0] val_i,
   output logic [OUT_W-1:0]        out_o
);

   localparam logic signed [ACC_W-1:0] HALF = ACC_W'(64'd1 << (FRAC_W - 1));
   localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((64'd1 << OUT_W) - 1);

   if (ACC_W <= OUT_W + FRAC_W) begin : g_bad_width
      $error("sar_round_sat: ACC_W too narrow for OUT_W + FRAC_W");
   end

   logic signed [ACC_W-1:0] scaled;

   if (ROUND_NEAREST) begin : g_nearest
      assign scaled = (val_i + HALF) >>> FRAC_W;
   end else begin : g_floor
      assign scaled = val_i >>> FRAC_W;
   end

   always_comb begin
      if (scaled < 0) begin
         out_o = '0;
      end else if (scaled > MAXV) begin
         out_o = {OUT_W{1'b1}};
      end else begin
         out_o = scaled[OUT_W-1:0];
      end
   end

endmodule

// File: rtl/sar_weight_lms.sv
module sar_weight_lms #(
   parameter int     RAW_W   = 14,
   parameter int     WGT_W   = 24,
   parameter int     ACC_W   = 30,
   parameter int     SHIFT_W = 5,
   parameter longint LSB_WGT = 152,
   parameter longint RADIX_Q = 476,
   parameter longint NOM_OFS = 6400
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    upd_en_i,
   input  logic                    freeze_i,
   input  logic [SHIFT_W-1:0]      shift_i,
   input  logic signed [ACC_W-1:0] err_i,
   input  logic [RAW_W-1:0]        code_pos_i,
   input  logic [RAW_W-1:0]        code_neg_i,
   output logic signed [WGT_W-1:0] wgt_o [RAW_W],
   output logic signed [WGT_W-1:0] ofs_o
);

   logic signed [WGT_W-1:0] w_q [RAW_W];
   logic signed [WGT_W-1:0] ofs_q;
   logic signed [ACC_W-1:0] step_full;
   logic signed [WGT_W-1:0] step;
   logic                    learn;

   assign learn     = upd_en_i & ~freeze_i;
   assign step_full = err_i >>> shift_i;
   assign step      = step_full[WGT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < RAW_W; k++) begin
            w_q[k] <= WGT_W'(sar_cal_pkg::nominal_weight(k, LSB_WGT, RADIX_Q));
         end
         ofs_q <= WGT_W'(NOM_OFS);
      end else if (learn) begin
         for (int k = 0; k < RAW_W; k++) begin
            case ({code_pos_i[k], code_neg_i[k]})
               2'b10:   w_q[k] <= w_q[k] - step;
               2'b01:   w_q[k] <= w_q[k] + step;
               default: w_q[k] <= w_q[k];
            endcase
         end
         ofs_q <= ofs_q + step;
      end
   end

   assign wgt_o = w_q;
   assign ofs_o = ofs_q;

   // R7: frozen cycles never move the learned state
   p_freeze_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      freeze_i |=> ($stable(ofs_q) && $stable(w_q[RAW_W-1]) && $stable(w_q[0])));

   // R5: only a completed pair changes the offset estimate
   p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en_i |=> $stable(ofs_q));

endmodule

// File: rtl/sar_perturb_cal.sv
module sar_perturb_cal #(
   parameter int     RAW_W         = 14,
   parameter int     OUT_W         = 12,
   parameter int     FRAC_W        = 8,
   parameter int     WGT_W         = 24,
   parameter int     SHIFT_W       = 5,
   parameter longint LSB_WGT       = 152,
   parameter longint RADIX_Q       = 476,
   parameter longint NOM_OFS       = 6400,
   parameter bit     ROUND_NEAREST = 1'b1,
   localparam int    ACC_W         = WGT_W + $clog2(RAW_W) + 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               freeze,
   input  logic [SHIFT_W-1:0] step_shift,
   input  logic               code_valid,
   input  logic [RAW_W-1:0]   code,
   output logic               out_valid,
   output logic [OUT_W-1:0]   out_data,
   output logic [ACC_W-1:0]   err_data
);
   import sar_cal_pkg::*;

   localparam int EXT_W = ACC_W - WGT_W;

   if (RAW_W <= OUT_W) begin : g_bad_raw
      $error("sar_perturb_cal: RAW_W must exceed OUT_W for redundancy");
   end
   if (WGT_W < OUT_W + FRAC_W + 2) begin : g_bad_wgt
      $error("sar_perturb_cal: WGT_W too narrow");
   end
   if (FRAC_W < 1) begin : g_bad_frac
      $error("sar_perturb_cal: FRAC_W must be at least 1");
   end

   cal_phase_e              phase_q;
   logic signed [ACC_W-1:0] dpos_q;
   logic [RAW_W-1:0]        code_pos_q;
   logic signed [WGT_W-1:0] wgt [RAW_W];
   logic signed [WGT_W-1:0] ofs;
   logic signed [ACC_W-1:0] d_now;
   logic signed [ACC_W-1:0] ofs_ext;
   logic signed [ACC_W-1:0] pair_err;
   logic signed [ACC_W-1:0] pair_sum;
   logic signed [ACC_W-1:0] round_in;
   logic [OUT_W-1:0]        rounded;
   logic                    take_pos;
   logic                    pair_done;
   logic                    single;

   assign take_pos  = code_valid & ~freeze & (phase_q == PH_POS);
   assign pair_done = code_valid & ~freeze & (phase_q == PH_NEG);
   assign single    = code_valid & freeze;

   sar_code_weigher #(
      .RAW_W(RAW_W), .WGT_W(WGT_W), .ACC_W(ACC_W)
   ) weigher_i (
      .code_i(code), .wgt_i(wgt), .sum_o(d_now)
   );

   sar_weight_lms #(
      .RAW_W(RAW_W), .WGT_W(WGT_W), .ACC_W(ACC_W), .SHIFT_W(SHIFT_W),
      .LSB_WGT(LSB_WGT), .RADIX_Q(RADIX_Q), .NOM_OFS(NOM_OFS)
   ) lms_i (
      .clk(clk), .rst_n(rst_n), .upd_en_i(pair_done), .freeze_i(freeze),
      .shift_i(step_shift), .err_i(pair_err), .code_pos_i(code_pos_q),
      .code_neg_i(code), .wgt_o(wgt), .ofs_o(ofs)
   );

   assign ofs_ext  = {{EXT_W{ofs[WGT_W-1]}}, ofs};
   assign pair_err = dpos_q - d_now - (ofs_ext <<< 1);
   assign pair_sum = dpos_q + d_now;
   assign round_in = freeze ? d_now : (pair_sum >>> 1);

   sar_round_sat #(
      .ACC_W(ACC_W), .OUT_W(OUT_W), .FRAC_W(FRAC_W), .ROUND_NEAREST(ROUND_NEAREST)
   ) round_i (
      .val_i(round_in), .out_o(rounded)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_POS;
         dpos_q     <= '0;
         code_pos_q <= '0;
      end else if (freeze) begin
         phase_q    <= PH_POS;
      end else if (take_pos) begin
         phase_q    <= PH_NEG;
         dpos_q     <= d_now;
         code_pos_q <= code;
      end else if (pair_done) begin
         phase_q    <= PH_POS;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         err_data  <= '0;
      end else begin
         out_valid <= pair_done | single;
         if (pair_done | single) begin
            out_data <= rounded;
         end
         if (pair_done) begin
            err_data <= pair_err;
         end
      end
   end

   // R3: second code of a pair yields a result next cycle
   p_pair_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (code_valid && !freeze && phase_q == PH_NEG) |=> out_valid);

   // R3: first code of a pair yields nothing
   p_first_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (code_valid && !freeze && phase_q == PH_POS) |=> !out_valid);

   // R7: frozen code converts alone
   p_single_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (code_valid && freeze) |=> out_valid);

   // R8: freeze returns the pairing to the positive code
   p_phase_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |=> (phase_q == PH_POS));

   // R11: no code accepted, no result
   p_idle_novalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !code_valid |=> (!out_valid && $stable(out_data)));

endmodule

// File: tb/sar_perturb_cal_tb_top.sv
module sar_perturb_cal_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NB = 14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        freeze = 1'b0;
   logic [4:0]  step_shift = '0;
   logic        code_valid = 1'b0;
   logic [13:0] code = '0;
   logic        out_valid;
   logic [11:0] out_data;
   logic [29:0] err_data;

   int vectors = 0;
   int fails = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sar_perturb_cal dut_i (
      .clk(clk), .rst_n(rst_n), .freeze(freeze), .step_shift(step_shift),
      .code_valid(code_valid), .code(code), .out_valid(out_valid),
      .out_data(out_data), .err_data(err_data)
   );

   // behavioural reference state
   longint mw [NB];
   longint tw [NB];
   longint mofs, mdpos, ed, ee;
   logic [13:0] mcode;
   int mphase;
   bit ev;
   string cur_tag;

   function automatic longint nom_w(input int i);
      longint w = 152;
      for (int k = 0; k < i; k++) w = (w * 476) / 256;
      return w;
   endfunction

   function automatic longint rsat(input longint x);
      longint r = (x + 128) >>> 8;
      if (r < 0) return 0;
      if (r > 4095) return 4095;
      return r;
   endfunction

   function automatic longint wsum(input logic [13:0] c);
      longint s = 0;
      for (int i = 0; i < NB; i++) if (c[i]) s += mw[i];
      return s;
   endfunction

   function automatic logic [13:0] sar_quant(input longint x);
      logic [13:0] b = '0;
      longint r = x;
      for (int i = NB - 1; i >= 0; i--) begin
         if (r >= tw[i]) begin
            b[i] = 1'b1;
            r -= tw[i];
         end
      end
      return b;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < NB; i++) mw[i] = nom_w(i);
      mofs = 6400; mdpos = 0; mcode = '0; mphase = 0;
      ev = 0; ed = 0; ee = 0;
   endtask

   task automatic model_step(input bit v, input logic [13:0] c, input bit f, input int sh);
      longint d, e, u;
      ev = 0;
      if (v) begin
         d = wsum(c);
         if (f) begin
            ev = 1; ed = rsat(d);
         end else if (mphase == 0) begin
            mdpos = d; mcode = c; mphase = 1;
         end else begin
            e = mdpos - d - 2 * mofs;
            ev = 1; ed = rsat((mdpos + d) >>> 1); ee = e;
            u = e >>> sh;
            for (int i = 0; i < NB; i++) begin
               if (mcode[i] && !c[i]) mw[i] -= u;
               else if (!mcode[i] && c[i]) mw[i] += u;
            end
            mofs += u;
            mphase = 0;
         end
      end
      if (f) mphase = 0;
   endtask

   task automatic check_outputs();
      longint act_e;
      act_e = longint'($signed(err_data));
      vectors++;
      if (out_valid !== ev) begin
         fails++;
         $display("FAIL %s: out_valid actual=%0b expected=%0b", cur_tag, out_valid, ev);
      end
      vectors++;
      if (longint'(out_data) != ed) begin
         fails++;
         $display("FAIL %s: out_data actual=%0d expected=%0d", cur_tag, out_data, ed);
      end
      vectors++;
      if (act_e != ee) begin
         fails++;
         $display("FAIL %s: err_data actual=%0d expected=%0d", cur_tag, act_e, ee);
      end
   endtask

   task automatic tick(input bit v, input logic [13:0] c, input bit f, input int sh,
                       input string tag);
      check_outputs();
      code_valid = v; code = c; freeze = f; step_shift = 5'(sh);
      model_step(v, c, f, sh);
      cur_tag = tag;
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; code_valid = 1'b0; freeze = 1'b0; code = '0;
      model_reset();
      @(negedge clk);
      @(negedge clk);
      cur_tag = "R10 reset state";
      check_outputs();
      rst_n = 1'b1;
      cur_tag = "R10 after reset";
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      if (!done) begin
         fails++;
         $display("FAIL R11 watchdog: actual=hung expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      longint x, dlt;
      cur_tag = "R10 reset state";
      do_reset();

      // R1 R2 R7: nominal weights through frozen single conversions
      tick(1, 14'd1, 1, 0, "R1 LSB weight");
      for (int i = 0; i < NB; i++) tick(1, 14'(1 << i), 1, 0, "R1 R2 single bit");
      tick(1, 14'h0000, 1, 0, "R9 zero code");
      tick(1, 14'h3FFF, 1, 0, "R2 all ones");
      tick(1, 14'h2AAA, 1, 0, "R2 alternating");
      tick(0, 14'h1555, 1, 0, "R11 idle hold");
      tick(0, 14'h0, 0, 0, "R11 idle");

      // R3 R4 R5 R6: simple pairs, weights seen on next code
      tick(1, 14'h2000, 0, 3, "R3 first code silent");
      tick(1, 14'h1FFF, 0, 3, "R3 R4 R5 pair");
      tick(1, 14'h3FFF, 1, 0, "R5 updated weights visible");
      tick(1, 14'h0123, 0, 4, "R3 first");
      tick(0, 14'h0, 0, 4, "R11 gap inside pair");
      tick(1, 14'h0100, 0, 4, "R6 pair after gap");
      tick(0, 14'h0, 0, 0, "R6 result");

      // R8: freeze mid-pair clears pairing
      tick(1, 14'h0800, 0, 2, "R3 first before freeze");
      tick(0, 14'h0, 1, 2, "R8 freeze no code");
      tick(1, 14'h0400, 0, 2, "R8 restart positive");
      tick(1, 14'h0300, 0, 2, "R8 completes pair");
      tick(1, 14'h0700, 1, 2, "R7 frozen single");
      tick(0, 14'h0, 0, 0, "R7 result");

      // R9: push weights to extremes with zero gain shift
      do_reset();
      tick(1, 14'h3FFF, 0, 0, "R3 extreme first");
      tick(1, 14'h0000, 0, 0, "R5 extreme pair");
      tick(1, 14'h3FFF, 1, 0, "R9 negative value low clamp");
      tick(1, 14'h0000, 0, 2, "R3 first");
      tick(1, 14'h3FFF, 0, 2, "R9 pair low clamp");
      tick(1, 14'h3FFF, 1, 0, "R9 high clamp");
      tick(0, 14'h0, 0, 0, "R9 result");

      // R4 R5 R6: background learning with mismatched true weights
      do_reset();
      for (int i = 0; i < NB; i++) tw[i] = nom_w(i) + ((i % 3) - 1) * (nom_w(i) / 48);
      dlt = 6400 + 700;
      for (int n = 0; n < 1500; n++) begin
         x = longint'($urandom_range(20000, 900000));
         if (n % 97 == 50) begin
            tick(1, sar_quant(x), 1, 9, "R7 interleaved single");
         end
         tick(1, sar_quant(x + dlt), 0, 9, "R3 learning first");
         if (n % 7 == 3) tick(0, 14'h0, 0, 9, "R11 learning gap");
         tick(1, sar_quant(x - dlt), 0, 9, "R4 R5 R6 learning pair");
      end
      tick(0, 14'h0, 0, 0, "R6 final");
      check_outputs();

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule